// File: doc/BRIEF.md
# High/Low Phase Clock Divider

This block derives the clock for a memory-card interface from a fast base clock (nominally 208 MHz). An 8-bit divide setting carries two 4-bit counts. The upper count fixes how many base cycles the output stays high, and the lower count fixes how many it stays low. Each count is stored as length minus one. The output period is therefore the sum of the two phase lengths, and an odd divisor still gives a duty cycle within one base cycle of 50%. The block drives a registered divided clock level and a one-cycle enable pulse that marks each rising edge, both in the base-clock domain.

A write strobe loads the setting register. The divider copies a new value into its working setting only at the end of a complete low phase, so a pulse already in progress is never cut short. A setting whose high and low counts differ by more than one cycle is refused. Two mode inputs change the source of the output. A memory-stick select swaps in a fixed built-in setting. A low-power select makes the output track a slow reference clock (nominally 13 MHz) in place of the divided base clock.

The sequencer has four states, and each transition is named here:
- `ST_HOLD` is the reset state. On the first cycle out of reset it goes to `ST_HIGH` and loads the working setting, or goes to `ST_SLOW` if low power is selected.
- `ST_HIGH` counts down the high count, then goes to `ST_LOW`.
- `ST_LOW` counts down the low count. It then goes to `ST_HIGH` and loads the working setting, or goes to `ST_SLOW` when low power is selected.
- `ST_SLOW` waits until low power is released and the reference is low, then goes to `ST_HIGH` and loads the working setting.

Top module: `phase_clk_div`

## Requirements
- R1: While reset is active, `div_clk` and `div_en` are 0 and `setting_q` reads 0x0054. After reset the output runs with 6 cycles high and 5 cycles low.
- R2: Each period starts with a high phase of `setting[7:4]`+1 base cycles. A low phase of `setting[3:0]`+1 base cycles follows it.
- R3: The divide ratio is the sum of the two phase lengths. The settings 0x54, 0x44, 0x43, 0x33, 0x32, 0x22, 0x21, 0x11 and 0x00 give ratios 11, 10, 9, 8, 7, 6, 5, 4 and 2.
- R4: `div_en` is high for exactly one cycle per period, in the cycle where `div_clk` goes from 0 to 1, and is 0 in every other cycle.
- R5: A write that lands during a period leaves that period's high and low lengths unchanged. The new setting takes effect with the next high phase.
- R6: A setting is applied only when its high count equals its low count or exceeds it by exactly one. Any other setting is stored and read back, but the divider keeps running with its previous working setting.
- R7: The setting register is 16 bits wide. Every written bit reads back on `setting_q`. Bits 15:8 have no effect on the output.
- R8: With `stick_mode` at 1, the divider uses the built-in setting 0x21 (3 cycles high, 2 cycles low) from the next high phase on. `setting_q` is not affected. Clearing `stick_mode` returns the divider to the register setting.
- R9: With `low_power` at 1, once the current low phase ends, `div_clk` equals the value `slow_ref` had one base cycle earlier. `div_en` still marks each rising edge.
- R10: After `low_power` returns to 0, the divider restarts with a full high phase of the working setting once `slow_ref` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_wdata | input | 16 | Value to write to the setting register |
| set_we | input | 1 | Write strobe for the setting register |
| stick_mode | input | 1 | 1 selects the built-in memory-stick setting |
| low_power | input | 1 | 1 makes the output follow `slow_ref` |
| slow_ref | input | 1 | Slow reference clock level, sampled on `clk` |
| div_clk | output | 1 | Registered divided clock level |
| div_en | output | 1 | One-cycle pulse at each rising edge of `div_clk` |
| setting_q | output | 16 | Current contents of the setting register |

## Verification
The hardest situation to reach from the ports is a write that lands in the middle of a phase. In that case the bench must tell the still-running old period apart from the first new one. The stimulus waits at a falling clock edge until it sees `div_clk` rise, raises the write strobe in that same cycle, and then measures three consecutive phases against the old and new lengths. The handover into and out of the slow-reference mode is reached in a similar way. The bench toggles `slow_ref` on a fixed schedule, waits longer than the longest possible period, and only then compares the output with the reference cycle by cycle.

// File: rtl/phdiv_pkg.sv
package phdiv_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2,
        ST_SLOW = 2'd3
    } phdiv_state_e;

endpackage

// File: rtl/phdiv_cfg.sv
module phdiv_cfg #(
    parameter int               REG_W       = 16,
    parameter int               SET_W       = 8,
    parameter logic [REG_W-1:0] DEFAULT_SET = 16'h0054,
    parameter logic [SET_W-1:0] STICK_SET   = 8'h21
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [REG_W-1:0]   wdata,
    input  logic               we,
    input  logic               stick_mode,
    input  logic               load,
    output logic [REG_W-1:0]   setting_q,
    output logic [SET_W/2-1:0] act_hi,
    output logic [SET_W/2-1:0] act_lo,
    output logic [SET_W/2-1:0] nxt_hi
);

    localparam int NIB_W = SET_W / 2;

    logic [REG_W-1:0] pend_q;
    logic [SET_W-1:0] act_q;
    logic [SET_W-1:0] src;
    logic [NIB_W-1:0] src_hi;
    logic [NIB_W-1:0] src_lo;
    logic             src_ok;
    logic [SET_W-1:0] act_d;

    // Register write: full width stored, only the low field feeds the divider.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= DEFAULT_SET;
        else if (we)
            pend_q <= wdata;
    end

    // Candidate source and its legality: high equals low, or low plus one.
    always_comb begin
        src    = stick_mode ? STICK_SET : pend_q[SET_W-1:0];
        src_hi = src[SET_W-1:NIB_W];
        src_lo = src[NIB_W-1:0];
        src_ok = ({1'b0, src_hi} == {1'b0, src_lo}) ||
                 ({1'b0, src_hi} == ({1'b0, src_lo} + 1'b1));
        act_d  = src_ok ? src : act_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            act_q <= DEFAULT_SET[SET_W-1:0];
        else if (load)
            act_q <= act_d;
    end

    assign setting_q = pend_q;
    assign act_hi    = act_q[SET_W-1:NIB_W];
    assign act_lo    = act_q[NIB_W-1:0];
    assign nxt_hi    = load ? act_d[SET_W-1:NIB_W] : act_q[SET_W-1:NIB_W];

    p_act_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_hi == act_lo) || ({1'b0, act_hi} == ({1'b0, act_lo} + 1'b1)));

    p_act_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act_q));

    p_pend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(pend_q));

    p_stick_use_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && stick_mode) |=> (act_q == STICK_SET));

endmodule

// File: rtl/phdiv_fsm.sv
module phdiv_fsm
    import phdiv_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             low_power,
    input  logic             slow_ref,
    input  logic [NIB_W-1:0] act_lo,
    input  logic [NIB_W-1:0] nxt_hi,
    output phdiv_state_e     state_q,
    output phdiv_state_e     state_d,
    output logic             load
);

    logic [NIB_W-1:0] cnt_q;
    logic [NIB_W-1:0] cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state and phase counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        load    = 1'b0;
        unique case (state_q)
            ST_HOLD: begin
                if (low_power) begin
                    state_d = ST_SLOW;
                end else begin
                    load    = 1'b1;
                    state_d = ST_HIGH;
                    cnt_d   = nxt_hi;
                end
            end
            ST_HIGH: begin
                if (cnt_q == '0) begin
                    state_d = ST_LOW;
                    cnt_d   = act_lo;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_LOW: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end else if (low_power) begin
                    state_d = ST_SLOW;
                end else begin
                    load    = 1'b1;
                    state_d = ST_HIGH;
                    cnt_d   = nxt_hi;
                end
            end
            ST_SLOW: begin
                if (!low_power && !slow_ref) begin
                    load    = 1'b1;
                    state_d = ST_HIGH;
                    cnt_d   = nxt_hi;
                end
            end
        endcase
    end

    p_high_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIGH && cnt_q != '0) |=>
            (state_q == ST_HIGH && cnt_q == $past(cnt_q) - 1'b1));

    p_low_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOW && cnt_q != '0) |=>
            (state_q == ST_LOW && cnt_q == $past(cnt_q) - 1'b1));

    p_load_point_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> ((state_q == ST_LOW && cnt_q == '0) ||
                  state_q == ST_HOLD || state_q == ST_SLOW));

    p_slow_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SLOW && state_d == ST_SLOW) |-> low_power);

    p_slow_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLOW && state_d == ST_HIGH) |-> (!low_power && !slow_ref));

endmodule

// File: rtl/phdiv_out.sv
module phdiv_out
    import phdiv_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  phdiv_state_e state_d,
    input  logic         slow_ref,
    output logic         div_clk,
    output logic         div_en
);

    logic out_d;

    always_comb begin
        out_d = (state_d == ST_HIGH) || (state_d == ST_SLOW && slow_ref);
    end

    // Output registers: the level and its rising-edge marker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_clk <= 1'b0;
            div_en  <= 1'b0;
        end else begin
            div_clk <= out_d;
            div_en  <= out_d && !div_clk;
        end
    end

    p_en_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        div_en |-> (div_clk && !$past(div_clk)));

    p_rise_marked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (div_clk && !$past(div_clk)) |-> div_en);

    p_slow_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_d == ST_SLOW) |=> (div_clk == $past(slow_ref)));

endmodule

// File: rtl/phase_clk_div.sv
module phase_clk_div
    import phdiv_pkg::*;
#(
    parameter int               REG_W       = 16,
    parameter int               SET_W       = 8,
    parameter logic [REG_W-1:0] DEFAULT_SET = 16'h0054,
    parameter logic [SET_W-1:0] STICK_SET   = 8'h21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_wdata,
    input  logic             set_we,
    input  logic             stick_mode,
    input  logic             low_power,
    input  logic             slow_ref,
    output logic             div_clk,
    output logic             div_en,
    output logic [REG_W-1:0] setting_q
);

    localparam int NIB_W = SET_W / 2;

    logic [NIB_W-1:0] act_hi;
    logic [NIB_W-1:0] act_lo;
    logic [NIB_W-1:0] nxt_hi;
    logic             load;
    phdiv_state_e     state_q;
    phdiv_state_e     state_d;

    phdiv_cfg #(
        .REG_W      (REG_W),
        .SET_W      (SET_W),
        .DEFAULT_SET(DEFAULT_SET),
        .STICK_SET  (STICK_SET)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wdata     (set_wdata),
        .we        (set_we),
        .stick_mode(stick_mode),
        .load      (load),
        .setting_q (setting_q),
        .act_hi    (act_hi),
        .act_lo    (act_lo),
        .nxt_hi    (nxt_hi)
    );

    phdiv_fsm #(
        .NIB_W(NIB_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .low_power(low_power),
        .slow_ref (slow_ref),
        .act_lo   (act_lo),
        .nxt_hi   (nxt_hi),
        .state_q  (state_q),
        .state_d  (state_d),
        .load     (load)
    );

    phdiv_out u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_d (state_d),
        .slow_ref(slow_ref),
        .div_clk (div_clk),
        .div_en  (div_en)
    );

    p_quiet_after_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!div_clk && !div_en && state_q == ST_HOLD));

    p_high_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIGH) |-> div_clk);

endmodule

// File: tb/phase_clk_div_test.sv
module phase_clk_div_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] set_wdata;
    logic        set_we;
    logic        stick_mode;
    logic        low_power;
    logic        slow_ref;
    logic        div_clk;
    logic        div_en;
    logic [15:0] setting_q;

    int vectors = 0;
    int errors  = 0;

    always #4 clk = ~clk;

    phase_clk_div uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_wdata (set_wdata),
        .set_we    (set_we),
        .stick_mode(stick_mode),
        .low_power (low_power),
        .slow_ref  (slow_ref),
        .div_clk   (div_clk),
        .div_en    (div_en),
        .setting_q (setting_q)
    );

    function automatic bit pair_ok(logic [7:0] s);
        int hi = int'(s[7:4]);
        int lo = int'(s[3:0]);
        return (hi == lo) || (hi == lo + 1);
    endfunction

    function automatic int high_len(logic [7:0] s);
        return int'(s[7:4]) + 1;
    endfunction

    function automatic int low_len(logic [7:0] s);
        return int'(s[3:0]) + 1;
    endfunction

    task automatic check_eq(string tag, int got, int exp);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wr(logic [15:0] v);
        @(negedge clk);
        set_wdata = v;
        set_we    = 1'b1;
        @(negedge clk);
        set_we    = 1'b0;
    endtask

    task automatic sync_rise();
        do @(negedge clk); while (div_clk !== 1'b0);
        do @(negedge clk); while (div_clk !== 1'b1);
    endtask

    // Called at the sample where div_clk has just risen; returns at the next rise.
    task automatic measure(bit drop_we, output int h, output int l, output int en_bad);
        h = 1;
        l = 0;
        en_bad = 0;
        @(negedge clk);
        if (drop_we) set_we = 1'b0;
        while (div_clk === 1'b1) begin
            h++;
            if (div_en) en_bad++;
            @(negedge clk);
        end
        while (div_clk === 1'b0) begin
            l++;
            if (div_en) en_bad++;
            @(negedge clk);
        end
    endtask

    task automatic check_period(string tag, int eh, int el);
        int h, l, eb;
        sync_rise();
        check_eq({tag, " R4 enable at rise"}, int'(div_en), 1);
        measure(1'b0, h, l, eb);
        check_eq({tag, " R2 high length"}, h, eh);
        check_eq({tag, " R2 low length"}, l, el);
        check_eq({tag, " R4 stray enables"}, eb, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        vectors++;
        $display("FAIL R2 watchdog expired: got 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [7:0]  sup [9];
        int          div_exp [9];
        logic [7:0]  model;
        logic [15:0] v;
        int h, l, eb;

        sup = '{8'h54, 8'h44, 8'h43, 8'h33, 8'h32, 8'h22, 8'h21, 8'h11, 8'h00};
        div_exp = '{11, 10, 9, 8, 7, 6, 5, 4, 2};
        void'($urandom(32'd1234));

        rst_n = 1'b0; set_wdata = '0; set_we = 1'b0;
        stick_mode = 1'b0; low_power = 1'b0; slow_ref = 1'b0;
        repeat (5) @(negedge clk);
        check_eq("R1 div_clk in reset", int'(div_clk), 0);
        check_eq("R1 div_en in reset", int'(div_en), 0);
        check_eq("R1 setting_q in reset", int'(setting_q), 16'h0054);
        rst_n = 1'b1;
        check_period("R1 default", 6, 5);
        model = 8'h54;

        // R3: every supported setting
        for (int i = 0; i < 9; i++) begin
            wr({8'h00, sup[i]});
            sync_rise();
            check_eq("R4 enable at rise", int'(div_en), 1);
            measure(1'b0, h, l, eb);
            check_eq("R3 divide ratio", h + l, div_exp[i]);
            check_eq("R2 high length", h, high_len(sup[i]));
            check_eq("R4 stray enables", eb, 0);
        end

        // R5: write landing right after a rising edge
        wr(16'h0054);
        sync_rise();
        set_wdata = 16'h0011;
        set_we    = 1'b1;
        measure(1'b1, h, l, eb);
        check_eq("R5 old high kept", h, 6);
        check_eq("R5 old low kept", l, 5);
        check_eq("R5 enable at new rise", int'(div_en), 1);
        measure(1'b0, h, l, eb);
        check_eq("R5 new high", h, 2);
        check_eq("R5 new low", l, 2);

        // R6: unbalanced settings are refused
        wr(16'h0033);
        check_period("R6 base", 4, 4);
        wr(16'h0025);
        check_eq("R6 readback", int'(setting_q), 16'h0025);
        check_period("R6 hi<lo refused", 4, 4);
        wr(16'h00F0);
        check_period("R6 hi>>lo refused", 4, 4);
        wr(16'h000F);
        check_period("R6 wrap refused", 4, 4);

        // R7: upper byte stored, ignored by divider
        wr(16'hA522);
        check_eq("R7 readback", int'(setting_q), 16'hA522);
        check_period("R7 upper A5", 3, 3);
        wr(16'h5A22);
        check_eq("R7 readback", int'(setting_q), 16'h5A22);
        check_period("R7 upper 5A", 3, 3);

        // R8: memory-stick mode
        stick_mode = 1'b1;
        sync_rise();
        check_period("R8 stick", 3, 2);
        check_eq("R8 register untouched", int'(setting_q), 16'h5A22);
        stick_mode = 1'b0;
        sync_rise();
        check_period("R8 back to register", 3, 3);
        model = 8'h22;

        // R2/R3/R6: constrained random settings
        for (int i = 0; i < 30; i++) begin
            int lo = int'($urandom_range(0, 14));
            int hi = lo + int'($urandom_range(0, 1));
            v[15:8] = 8'($urandom);
            if ($urandom_range(0, 3) != 0)
                v[7:0] = {4'(hi), 4'(lo)};
            else
                v[7:0] = 8'($urandom);
            if (pair_ok(v[7:0])) model = v[7:0];
            wr(v);
            check_eq("R7 random readback", int'(setting_q), int'(v));
            check_period("R6 random", high_len(model), low_len(model));
        end

        // R9: follow the slow reference
        wr(16'h0076);
        model = 8'h76;
        @(negedge clk);
        low_power = 1'b1;
        begin
            bit prev = 1'b0;
            for (int i = 0; i < 160; i++) begin
                @(negedge clk);
                if (i >= 40) begin
                    check_eq("R9 follows slow_ref", int'(div_clk), int'(slow_ref));
                    check_eq("R9 enable on rise", int'(div_en), int'(div_clk && !prev));
                end
                prev = div_clk;
                if (i % 8 == 7) slow_ref = ~slow_ref;
            end
        end

        // R10: leave low power
        @(negedge clk);
        low_power = 1'b0;
        slow_ref  = 1'b0;
        check_period("R10 resume", high_len(model), low_len(model));

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule